// File: doc/BRIEF.md
# DMA Peripheral Handshake Sequencer

This block runs the hardware handshaking loop of a chunked DMA engine. Once software has set the handshake enable and issued a go pulse, the sequencer waits on a vector of peripheral request lines. Each line is gated by its own enable bit. When an enabled line is asserted, the sequencer asks the transfer controller to move exactly one chunk, using a single-cycle start pulse and a done/error return. It can then clear the peripheral's request with one write. The address, value and target address space of that write come from a per-source table.

The loop counts bytes down from a programmed total. It finishes when the remaining count reaches zero, and the last chunk may be shorter than the chunk size. An abort, a chunk error or clearing the handshake enable sends the sequencer straight back to idle, and no acknowledge write is issued. While handshaking is on, the chunk-complete interrupt towards software is held low, because the peripheral request now paces the chunks.

Top module: `dma_hs_seq`

## Requirements
- R1: While `hs_en_i` is 0, `go_i` is ignored and `busy_o` stays 0. Dropping `hs_en_i` while busy returns the block to idle on the next clock.
- R2: A request bit `irq_i[i]` whose `irq_en_i[i]` is 0 never launches a chunk.
- R3: In the armed state, an enabled request sampled at a clock edge raises `chunk_start_o` for exactly one cycle, starting right after that edge. Only one chunk is launched per request.
- R4: When several enabled requests are pending, the lowest index is serviced first.
- R5: If `ack_en_i[s]` is 1 for the serviced source s, then on the cycle after a good `chunk_done_i` the block raises `wr_req_o`. It drives `wr_addr_o = ack_addr_i[s*AW +: AW]`, `wr_data_o = ack_val_i[s*DW +: DW]` and `wr_bus_o = ack_bus_i[s]`, and holds all of them until `wr_gnt_i`. No chunk is started while the write is pending.
- R6: If `ack_en_i[s]` is 0, no acknowledge write is issued for that chunk.
- R7: The remaining count is loaded from `total_bytes_i` at go, and each chunk takes off `chunk_bytes_i` (or the remainder, if that is smaller). After the chunk that brings it to zero, plus its acknowledge if one is enabled, `done_o` pulses for one cycle and `busy_o` drops in the same cycle.
- R8: `abort_i` returns the block to idle on the next cycle. A later `chunk_done_i` then causes no acknowledge write and no `done_o`.
- R9: `chunk_done_i` together with `chunk_err_i` returns the block to idle with no acknowledge write and no `done_o`.
- R10: `chunk_irq_o` follows `chunk_done_i` while `hs_en_i` is 0 and is held at 0 while `hs_en_i` is 1.
- R11: A go with `total_bytes_i` equal to 0 launches no chunk and pulses `done_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_en_i | input | 1 | Handshake mode enable |
| go_i | input | 1 | Start pulse for a handshake transfer |
| abort_i | input | 1 | Abort pulse |
| total_bytes_i | input | CW | Total bytes to move |
| chunk_bytes_i | input | CW | Bytes per chunk (nonzero) |
| irq_i | input | NSRC | Peripheral request lines |
| irq_en_i | input | NSRC | Per-line request enable |
| ack_en_i | input | NSRC | Per-source acknowledge enable |
| ack_bus_i | input | NSRC | Per-source acknowledge address-space select |
| ack_addr_i | input | NSRC*AW | Acknowledge address table, entry i at [i*AW +: AW] |
| ack_val_i | input | NSRC*DW | Acknowledge value table, entry i at [i*DW +: DW] |
| chunk_start_o | output | 1 | One-cycle chunk launch to the transfer controller |
| chunk_done_i | input | 1 | Chunk finished |
| chunk_err_i | input | 1 | Chunk failed, qualified by chunk_done_i |
| chunk_irq_o | output | 1 | Chunk-complete interrupt to software |
| wr_req_o | output | 1 | Acknowledge write request |
| wr_gnt_i | input | 1 | Acknowledge write accepted |
| wr_addr_o | output | AW | Acknowledge write address |
| wr_data_o | output | DW | Acknowledge write data |
| wr_bus_o | output | 1 | Acknowledge address-space select |
| busy_o | output | 1 | Sequencer not idle |
| done_o | output | 1 | One-cycle total-complete pulse |

## Verification
A request sampled at an edge shows up as `chunk_start_o` in the following cycle. The acknowledge request appears in the cycle after the done edge. `done_o` appears in the cycle after the final done edge, or after the final grant edge when an acknowledge is enabled. Abort and error return to idle in the cycle after their edge. The bench drives inputs and samples outputs on falling edges, and steps a fixed number of falling edges from each stimulus to the cycle where the result is due. A scoreboard queue also holds the expected order of launches, acknowledge writes and completions, so an extra or missing event is reported even when it happens outside a timed check.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  typedef enum logic [2:0] {
    HS_IDLE,
    HS_ARM,
    HS_START,
    HS_WAIT,
    HS_ACK
  } hs_state_e;
endpackage

// File: rtl/dma_hs_pick.sv
module dma_hs_pick #(
  parameter int N  = 11,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  // downward scan: last hit is the lowest index
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign vld_o = |req_i;
endmodule

// File: rtl/dma_hs_ack_table.sv
module dma_hs_ack_table #(
  parameter int N  = 11,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*AW-1:0] addr_tbl_i,
  input  logic [N*DW-1:0] val_tbl_i,
  input  logic [N-1:0]    bus_i,
  input  logic [N-1:0]    en_i,
  input  logic [IW-1:0]   sel_i,
  output logic            en_o,
  output logic            bus_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   data_o
);
  logic [AW-1:0] addr_a [N];
  logic [DW-1:0] val_a  [N];

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign addr_a[g] = addr_tbl_i[g*AW +: AW];
    assign val_a[g]  = val_tbl_i[g*DW +: DW];
  end

  always_comb begin
    en_o   = 1'b0;
    bus_o  = 1'b0;
    addr_o = '0;
    data_o = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_i == IW'(i)) begin
        en_o   = en_i[i];
        bus_o  = bus_i[i];
        addr_o = addr_a[i];
        data_o = val_a[i];
      end
    end
  end
endmodule

// File: rtl/dma_hs_bytecnt.sv
module dma_hs_bytecnt #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] total_i,
  input  logic          step_i,
  input  logic [CW-1:0] chunk_i,
  output logic          last_o,
  output logic          zero_o
);
  logic [CW-1:0] rem_q;

  assign last_o = (rem_q <= chunk_i);
  assign zero_o = (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (load_i) rem_q <= total_i;
    else if (step_i) rem_q <= last_o ? '0 : rem_q - chunk_i;
  end
endmodule

// File: rtl/dma_hs_seq.sv
module dma_hs_seq
  import dma_hs_pkg::*;
#(
  parameter int NSRC = 11,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CW   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_en_i,
  input  logic              go_i,
  input  logic              abort_i,
  input  logic [CW-1:0]     total_bytes_i,
  input  logic [CW-1:0]     chunk_bytes_i,
  input  logic [NSRC-1:0]   irq_i,
  input  logic [NSRC-1:0]   irq_en_i,
  input  logic [NSRC-1:0]   ack_en_i,
  input  logic [NSRC-1:0]   ack_bus_i,
  input  logic [NSRC*AW-1:0] ack_addr_i,
  input  logic [NSRC*DW-1:0] ack_val_i,
  output logic              chunk_start_o,
  input  logic              chunk_done_i,
  input  logic              chunk_err_i,
  output logic              chunk_irq_o,
  output logic              wr_req_o,
  input  logic              wr_gnt_i,
  output logic [AW-1:0]     wr_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic              wr_bus_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  hs_state_e state_q, state_d;
  logic [IW-1:0] src_q, src_d;
  logic          done_q, done_d;
  logic          pick_vld, ack_en, last, zero, load, step, stop;
  logic [IW-1:0] pick_idx;

  dma_hs_pick #(.N(NSRC), .IW(IW)) i_pick (
    .req_i (irq_i & irq_en_i),
    .vld_o (pick_vld),
    .idx_o (pick_idx)
  );

  dma_hs_ack_table #(.N(NSRC), .AW(AW), .DW(DW), .IW(IW)) i_tbl (
    .addr_tbl_i (ack_addr_i),
    .val_tbl_i  (ack_val_i),
    .bus_i      (ack_bus_i),
    .en_i       (ack_en_i),
    .sel_i      (src_q),
    .en_o       (ack_en),
    .bus_o      (wr_bus_o),
    .addr_o     (wr_addr_o),
    .data_o     (wr_data_o)
  );

  dma_hs_bytecnt #(.CW(CW)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .total_i (total_bytes_i),
    .step_i  (step),
    .chunk_i (chunk_bytes_i),
    .last_o  (last),
    .zero_o  (zero)
  );

  // abort or mode drop wins over every other transition
  assign stop = abort_i | ~hs_en_i;

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    done_d  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      HS_IDLE: begin
        if (go_i && hs_en_i && !abort_i) begin
          load = 1'b1;
          if (total_bytes_i == '0) done_d = 1'b1;
          else                     state_d = HS_ARM;
        end
      end
      HS_ARM: begin
        if (pick_vld) begin
          src_d   = pick_idx;
          state_d = HS_START;
        end
      end
      HS_START: state_d = HS_WAIT;
      HS_WAIT: begin
        if (chunk_done_i) begin
          if (chunk_err_i) begin
            state_d = HS_IDLE;
          end else begin
            step = 1'b1;
            if (ack_en) begin
              state_d = HS_ACK;
            end else if (last) begin
              state_d = HS_IDLE;
              done_d  = 1'b1;
            end else begin
              state_d = HS_ARM;
            end
          end
        end
      end
      HS_ACK: begin
        if (wr_gnt_i) begin
          if (zero) begin
            state_d = HS_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = HS_ARM;
          end
        end
      end
      default: state_d = HS_IDLE;
    endcase
    if (stop && state_q != HS_IDLE) begin
      state_d = HS_IDLE;
      done_d  = 1'b0;
      step    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      src_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      done_q  <= done_d;
    end
  end

  assign chunk_start_o = (state_q == HS_START);
  assign wr_req_o      = (state_q == HS_ACK);
  assign busy_o        = (state_q != HS_IDLE);
  assign done_o        = done_q;
  assign chunk_irq_o   = chunk_done_i & ~hs_en_i;
endmodule

// File: rtl/dma_hs_seq_chk.sv
module dma_hs_seq_chk #(
  parameter int NSRC = 11,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            hs_en_i,
  input logic            go_i,
  input logic            abort_i,
  input logic [NSRC-1:0] irq_i,
  input logic [NSRC-1:0] irq_en_i,
  input logic            chunk_start_o,
  input logic            chunk_done_i,
  input logic            chunk_err_i,
  input logic            wr_req_o,
  input logic            wr_gnt_i,
  input logic [AW-1:0]   wr_addr_o,
  input logic [DW-1:0]   wr_data_o,
  input logic            busy_o,
  input logic            done_o
);
  assert_idle_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(go_i && hs_en_i)) |=> !busy_o);

  assert_start_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chunk_start_o) |-> $past(|(irq_i & irq_en_i)));

  assert_start_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chunk_start_o |=> !chunk_start_o);

  assert_ack_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_gnt_i && !abort_i && hs_en_i) |=>
      (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  assert_no_start_in_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> !chunk_start_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_abort_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !wr_req_o));

  assert_err_no_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chunk_done_i && chunk_err_i && busy_o && !wr_req_o) |=> (!wr_req_o && !done_o));
endmodule

bind dma_hs_seq dma_hs_seq_chk #(.NSRC(NSRC), .AW(AW), .DW(DW)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hs_en_i       (hs_en_i),
  .go_i          (go_i),
  .abort_i       (abort_i),
  .irq_i         (irq_i),
  .irq_en_i      (irq_en_i),
  .chunk_start_o (chunk_start_o),
  .chunk_done_i  (chunk_done_i),
  .chunk_err_i   (chunk_err_i),
  .wr_req_o      (wr_req_o),
  .wr_gnt_i      (wr_gnt_i),
  .wr_addr_o     (wr_addr_o),
  .wr_data_o     (wr_data_o),
  .busy_o        (busy_o),
  .done_o        (done_o)
);

// File: tb/test_dma_hs_seq.sv
module test_dma_hs_seq;
  localparam int NSRC = 11;
  localparam int AW   = 32;
  localparam int DW   = 32;
  localparam int CW   = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hs_en_i = 1'b0, go_i = 1'b0, abort_i = 1'b0;
  logic [CW-1:0] total_bytes_i = '0, chunk_bytes_i = '0;
  logic [NSRC-1:0] irq_i = '0, irq_en_i = '0, ack_en_i = '0, ack_bus_i = '0;
  logic [NSRC*AW-1:0] ack_addr_i;
  logic [NSRC*DW-1:0] ack_val_i;
  logic chunk_start_o, chunk_done_i = 1'b0, chunk_err_i = 1'b0, chunk_irq_o;
  logic wr_req_o, wr_gnt_i = 1'b0, wr_bus_o, busy_o, done_o;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;

  always #2 clk_i = ~clk_i;

  dma_hs_seq #(.NSRC(NSRC), .AW(AW), .DW(DW), .CW(CW)) i_dma_hs_seq (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  typedef struct {int kind; logic [AW-1:0] a; logic [DW-1:0] d; logic b;} ev_t;
  ev_t exp_q[$];

  function automatic logic [AW-1:0] tbl_addr(int i); return 32'h4000_0000 + 32'(i * 16); endfunction
  function automatic logic [DW-1:0] tbl_val(int i);  return 32'hA500_0000 + 32'(i);      endfunction

  initial begin
    for (int i = 0; i < NSRC; i++) begin
      ack_addr_i[i*AW +: AW] = tbl_addr(i);
      ack_val_i[i*DW +: DW]  = tbl_val(i);
      ack_bus_i[i]           = 1'(i % 2);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input int kind, input int src);
    ev_t e;
    e.kind = kind; e.a = tbl_addr(src); e.d = tbl_val(src); e.b = 1'(src % 2);
    exp_q.push_back(e);
  endtask

  // monitor: kind 0 launch, 1 acknowledge, 2 completion
  logic req_d = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (chunk_start_o) begin
        if (exp_q.size() == 0 || exp_q[0].kind != 0) chk(0, "R3 launch order", 1, 0);
        else begin void'(exp_q.pop_front()); chk(1, "R3", 1, 1); end
      end
      if (wr_req_o && !req_d) begin
        if (exp_q.size() == 0 || exp_q[0].kind != 1) chk(0, "R6 unexpected ack", 1, 0);
        else begin
          chk(wr_addr_o == exp_q[0].a && wr_data_o == exp_q[0].d && wr_bus_o == exp_q[0].b,
              "R4 ack source", {wr_addr_o, wr_data_o}, {exp_q[0].a, exp_q[0].d});
          void'(exp_q.pop_front());
        end
      end
      if (done_o) begin
        if (exp_q.size() == 0 || exp_q[0].kind != 2) chk(0, "R7 unexpected done", 1, 0);
        else begin void'(exp_q.pop_front()); chk(1, "R7", 1, 1); end
      end
      req_d <= wr_req_o;
    end
  end

  task automatic go(input logic [CW-1:0] tot, input logic [CW-1:0] chk_sz);
    total_bytes_i = tot; chunk_bytes_i = chk_sz; go_i = 1'b1;
    @(negedge clk_i); go_i = 1'b0;
  endtask

  // called on the falling edge where the request is first presented in the armed state
  task automatic run_chunk(input int src, input bit ack, input bit last, input logic [NSRC-1:0] keep);
    push(0, src);
    if (ack) push(1, src);
    if (last) push(2, src);
    @(negedge clk_i);
    chk(chunk_start_o == 1'b1, "R3 start due", chunk_start_o, 1);
    @(negedge clk_i);
    chk(chunk_start_o == 1'b0, "R3 single pulse", chunk_start_o, 0);
    chunk_done_i = 1'b1; irq_i = keep;
    @(negedge clk_i); chunk_done_i = 1'b0;
    if (ack) begin
      chk(wr_req_o == 1'b1, "R5 ack due", wr_req_o, 1);
      @(negedge clk_i);
      chk(wr_req_o == 1'b1 && chunk_start_o == 1'b0, "R5 ack held", {wr_req_o, chunk_start_o}, 2'b10);
      wr_gnt_i = 1'b1;
      @(negedge clk_i); wr_gnt_i = 1'b0;
    end else begin
      chk(wr_req_o == 1'b0, "R6 no ack", wr_req_o, 0);
    end
    if (last) chk(done_o == 1'b1 && busy_o == 1'b0, "R7 finish", {done_o, busy_o}, 2'b10);
    else      chk(done_o == 1'b0 && busy_o == 1'b1, "R7 continue", {done_o, busy_o}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !chunk_start_o && !wr_req_o && !done_o, "R7 reset state",
        {busy_o, chunk_start_o, wr_req_o, done_o}, 0);

    // R1 / R10 with mode off
    irq_en_i = 11'b000_0010_0100;
    go(16'd4, 16'd4);
    irq_i = 11'b000_0000_0100;
    repeat (3) @(negedge clk_i);
    chk(busy_o == 1'b0, "R1 go ignored", busy_o, 0);
    irq_i = '0;
    chunk_done_i = 1'b1; #1;
    chk(chunk_irq_o == 1'b1, "R10 irq passes", chunk_irq_o, 1);
    @(negedge clk_i); chunk_done_i = 1'b0;

    // main loop: 10 bytes, chunk 4 -> 3 chunks
    hs_en_i = 1'b1;
    ack_en_i = 11'b000_0010_0000;
    go(16'd10, 16'd4);
    irq_i = 11'b000_0000_0001;                 // R2: line 0 is not enabled
    repeat (3) @(negedge clk_i);
    chk(busy_o == 1'b1 && chunk_start_o == 1'b0, "R2 masked line", {busy_o, chunk_start_o}, 2'b10);
    chunk_done_i = 1'b1; #1;
    chk(chunk_irq_o == 1'b0, "R10 irq held", chunk_irq_o, 0);
    @(negedge clk_i); chunk_done_i = 1'b0;
    irq_i = 11'b000_0010_0101;                 // R4: 2 before 5
    run_chunk(2, 1'b0, 1'b0, 11'b000_0010_0001);
    run_chunk(5, 1'b1, 1'b0, 11'b000_0010_0001);
    run_chunk(5, 1'b1, 1'b1, 11'b000_0000_0001);
    irq_i = '0;
    repeat (2) @(negedge clk_i);

    // R8 abort
    irq_en_i = 11'b000_0000_1000; ack_en_i = 11'b000_0000_1000;
    go(16'd8, 16'd4);
    irq_i = 11'b000_0000_1000;
    push(0, 3);
    @(negedge clk_i);
    @(negedge clk_i); abort_i = 1'b1;
    @(negedge clk_i); abort_i = 1'b0; irq_i = '0;
    chk(busy_o == 1'b0, "R8 abort idle", busy_o, 0);
    chunk_done_i = 1'b1;
    @(negedge clk_i); chunk_done_i = 1'b0;
    chk(wr_req_o == 1'b0 && done_o == 1'b0, "R8 no ack", {wr_req_o, done_o}, 0);
    @(negedge clk_i);

    // R9 chunk error
    go(16'd8, 16'd4);
    irq_i = 11'b000_0000_1000;
    push(0, 3);
    @(negedge clk_i);
    @(negedge clk_i); chunk_done_i = 1'b1; chunk_err_i = 1'b1;
    @(negedge clk_i); chunk_done_i = 1'b0; chunk_err_i = 1'b0;
    chk(!busy_o && !wr_req_o && !done_o, "R9 error idle", {busy_o, wr_req_o, done_o}, 0);
    irq_i = '0;
    @(negedge clk_i);

    // R1 mode drop while armed
    go(16'd8, 16'd4);
    hs_en_i = 1'b0;
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R1 mode drop", busy_o, 0);
    hs_en_i = 1'b1;

    // R11 zero total
    push(2, 0);
    go(16'd0, 16'd4);
    chk(done_o == 1'b1 && busy_o == 1'b0, "R11 zero total", {done_o, busy_o}, 2'b10);
    repeat (3) @(negedge clk_i);

    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule